// File: doc/BRIEF.md
# DAC Power-Mode Sequencer

This block holds and sequences the power state of a single-channel voltage-output DAC. A serial bus front end delivers each transfer already deserialized, as a command byte, a mode byte and a data word, marked by a one-cycle valid pulse. Bit 0 of the command byte says whether the transfer carries a power setting or a sample value. Either kind can be applied to the active registers at once or parked in a staging register. A load command, or a separate load strobe shared by several channels, later commits everything parked in one clock cycle. This is how a group of converters can change state together.

From the active state the block drives the amplifier enable, the fast-settling bias enable and three mutually exclusive output terminations. It also drives a ready flag. Ready drops while the output is powered down and stays low for a programmable wake-up interval after the output leaves power-down. Powering down never disturbs the held sample code.

Top module: `dac_pwr_ctrl`

## Requirements
- R1: After reset the block is in low-power normal mode: `amp_en`=1, `fast_bias_en`=0, all three terminations 0, `ready`=1, `dac_code`=0.
- R2: A power command has `cmd_byte[0]`=1 and `cmd_byte[7:1]` not all zero. It applies the setting in `mode_byte[7:5]` one cycle later. The encodings are: 000 low-power normal, 001 fast-settling normal, 01x power-down with a 1 kΩ pull to ground, 10x power-down with a 100 kΩ pull to ground, 11x power-down with a high-impedance output.
- R3: In every power-down state exactly one of `term_1k`, `term_100k`, `term_hiz` is 1, and `amp_en` and `fast_bias_en` are 0. In the normal modes no termination is 1 and `amp_en` is 1.
- R4: An apply-data command has `cmd_byte[0]`=0 and `cmd_byte[2:1]`=01. It puts `data_word` on `dac_code` one cycle later and leaves the low-power/fast-settling choice unchanged.
- R5: Any data update that reaches the active register, whether applied or loaded, and that comes without a power setting in the same commit, leaves power-down. It returns to the normal mode that was last selected.
- R6: Entering or changing power-down leaves `dac_code` unchanged.
- R7: A command byte of exactly 0x01 parks the power setting in staging. The outputs do not change.
- R8: A data command with `cmd_byte[2:1]`=00 parks `data_word` in staging. The outputs do not change.
- R9: A load command (`cmd_byte[0]`=0, `cmd_byte[2:1]`=10) or a `load_strobe` pulse commits the parked contents in one cycle. If both a setting and data are parked, the parked setting decides the mode. A commit empties staging, so a second load changes nothing.
- R10: `ready` is 0 throughout power-down. After the cycle in which power-down ends, it stays 0 for exactly `WAKE_CYCLES` cycles and then returns to 1.
- R11: Inputs are ignored while `cmd_valid` is 0, except `load_strobe`. A data command with `cmd_byte[2:1]`=11 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe marking a deserialized transfer |
| cmd_byte | input | 8 | Command byte |
| mode_byte | input | 8 | Power setting, fields in bits 7:5 |
| data_word | input | DATA_W | Sample code |
| load_strobe | input | 1 | Shared commit of the staging register |
| dac_code | output | DATA_W | Active sample code for the converter |
| amp_en | output | 1 | Output amplifier enable |
| fast_bias_en | output | 1 | Fast-settling bias enable |
| term_1k | output | 1 | Select 1 kΩ pull to ground |
| term_100k | output | 1 | Select 100 kΩ pull to ground |
| term_hiz | output | 1 | Select open output |
| ready | output | 1 | Output settled and usable |

## Verification
Every command, and every load pulse, takes effect on `dac_code`, the enables and the terminations at the first rising edge after it is presented. The bench drives each transfer on a falling edge, removes it on the next falling edge and samples there, exactly one register stage later. `ready` is due `WAKE_CYCLES` edges after the power-down exit. The wake checks therefore sample once per falling edge from the first edge after the exit and count the low samples, expecting exactly `WAKE_CYCLES` of them before the flag returns.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        PD_NONE = 2'd0,
        PD_1K   = 2'd1,
        PD_100K = 2'd2,
        PD_HIZ  = 2'd3
    } pd_t;

    typedef struct packed {
        logic fast;
        pd_t  pd;
    } pstate_t;

    typedef struct packed {
        logic stage_pwr;
        logic apply_pwr;
        logic stage_data;
        logic apply_data;
        logic load;
    } cmd_ev_t;

    localparam pstate_t PSTATE_RESET = '{fast: 1'b0, pd: PD_NONE};

    // Merge a power setting into the current state; the normal choice is kept
    // when the setting selects power-down so a later wake returns to it.
    function automatic pstate_t apply_setting(pstate_t cur, logic [7:0] m);
        pstate_t nxt;
        nxt = cur;
        unique case (m[7:6])
            2'b00: begin
                nxt.fast = m[5];
                nxt.pd   = PD_NONE;
            end
            2'b01:   nxt.pd = PD_1K;
            2'b10:   nxt.pd = PD_100K;
            default: nxt.pd = PD_HIZ;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/dpc_decode.sv
module dpc_decode
    import dpc_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output cmd_ev_t    ev
);

    logic is_pwr;
    logic park_pwr;

    always_comb begin
        is_pwr   = cmd_byte[0];
        park_pwr = (cmd_byte[7:1] == 7'd0);
        ev       = '0;
        if (cmd_valid) begin
            if (is_pwr) begin
                ev.stage_pwr = park_pwr;
                ev.apply_pwr = !park_pwr;
            end else begin
                unique case (cmd_byte[2:1])
                    2'b00:   ev.stage_data = 1'b1;
                    2'b01:   ev.apply_data = 1'b1;
                    2'b10:   ev.load       = 1'b1;
                    default: ev            = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dpc_stage.sv
module dpc_stage
    import dpc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_ev_t           ev,
    input  logic              commit,
    input  logic [7:0]        mode_byte,
    input  logic [DATA_W-1:0] data_word,
    output logic              park_pwr_vld,
    output logic [7:0]        park_mode,
    output logic              park_data_vld,
    output logic [DATA_W-1:0] park_data
);

    typedef struct packed {
        logic              pwr_vld;
        logic [7:0]        mode;
        logic              dat_vld;
        logic [DATA_W-1:0] dat;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a commit consumes what was parked before this cycle
        if (commit) begin
            st_d.pwr_vld = 1'b0;
            st_d.dat_vld = 1'b0;
        end
        if (ev.stage_pwr) begin
            st_d.pwr_vld = 1'b1;
            st_d.mode    = mode_byte;
        end
        if (ev.stage_data) begin
            st_d.dat_vld = 1'b1;
            st_d.dat     = data_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign park_pwr_vld  = st_q.pwr_vld;
    assign park_mode     = st_q.mode;
    assign park_data_vld = st_q.dat_vld;
    assign park_data     = st_q.dat;

endmodule

// File: rtl/dpc_core.sv
module dpc_core
    import dpc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int WAKE_CYCLES = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_ev_t           ev,
    input  logic              commit,
    input  logic [7:0]        mode_byte,
    input  logic [DATA_W-1:0] data_word,
    input  logic              park_pwr_vld,
    input  logic [7:0]        park_mode,
    input  logic              park_data_vld,
    input  logic [DATA_W-1:0] park_data,
    output pstate_t           pstate,
    output logic [DATA_W-1:0] code,
    output logic              ready
);

    localparam int CNT_W = (WAKE_CYCLES < 1) ? 1 : $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_CYCLES);

    typedef struct packed {
        pstate_t           ps;
        logic [DATA_W-1:0] code;
        logic [CNT_W-1:0]  wait_cnt;
    } core_t;

    core_t cs_d, cs_q;

    logic              pwr_hit;
    logic [7:0]        pwr_val;
    logic              dat_hit;
    logic [DATA_W-1:0] dat_val;
    logic              was_down;

    always_comb begin
        // an immediate command of the same kind wins over parked contents
        pwr_hit = ev.apply_pwr | (commit & park_pwr_vld);
        pwr_val = ev.apply_pwr ? mode_byte : park_mode;
        dat_hit = ev.apply_data | (commit & park_data_vld);
        dat_val = ev.apply_data ? data_word : park_data;

        was_down = (cs_q.ps.pd != PD_NONE);
        cs_d     = cs_q;

        if (dat_hit) begin
            cs_d.code = dat_val;
        end
        if (pwr_hit) begin
            cs_d.ps = apply_setting(cs_q.ps, pwr_val);
        end else if (dat_hit) begin
            cs_d.ps.pd = PD_NONE;
        end

        if (was_down && (cs_d.ps.pd == PD_NONE)) begin
            cs_d.wait_cnt = WAKE_LOAD;
        end else if (cs_q.wait_cnt != '0) begin
            cs_d.wait_cnt = cs_q.wait_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '{ps: PSTATE_RESET, code: '0, wait_cnt: '0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign pstate = cs_q.ps;
    assign code   = cs_q.code;
    assign ready  = (cs_q.ps.pd == PD_NONE) && (cs_q.wait_cnt == '0);

endmodule

// File: rtl/dpc_drive.sv
module dpc_drive
    import dpc_pkg::*;
#(
    parameter int N_TERM = 3
) (
    input  pstate_t           pstate,
    output logic              amp_en,
    output logic              fast_bias_en,
    output logic [N_TERM-1:0] term_sel
);

    logic awake;

    assign awake        = (pstate.pd == PD_NONE);
    assign amp_en       = awake;
    assign fast_bias_en = awake & pstate.fast;

    // termination k is selected by power-down code k+1
    for (genvar k = 0; k < N_TERM; k++) begin : g_term
        assign term_sel[k] = (pstate.pd == pd_t'(k + 1));
    end

endmodule

// File: rtl/dac_pwr_ctrl.sv
module dac_pwr_ctrl
    import dpc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int WAKE_CYCLES = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic [7:0]        mode_byte,
    input  logic [DATA_W-1:0] data_word,
    input  logic              load_strobe,
    output logic [DATA_W-1:0] dac_code,
    output logic              amp_en,
    output logic              fast_bias_en,
    output logic              term_1k,
    output logic              term_100k,
    output logic              term_hiz,
    output logic              ready
);

    localparam int N_TERM = 3;

    cmd_ev_t           ev;
    logic              commit;
    logic              park_pwr_vld;
    logic [7:0]        park_mode;
    logic              park_data_vld;
    logic [DATA_W-1:0] park_data;
    pstate_t           pstate;
    logic [N_TERM-1:0] term_sel;

    assign commit = ev.load | load_strobe;

    dpc_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .ev        (ev)
    );

    dpc_stage #(.DATA_W(DATA_W)) u_stage (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev            (ev),
        .commit        (commit),
        .mode_byte     (mode_byte),
        .data_word     (data_word),
        .park_pwr_vld  (park_pwr_vld),
        .park_mode     (park_mode),
        .park_data_vld (park_data_vld),
        .park_data     (park_data)
    );

    dpc_core #(.DATA_W(DATA_W), .WAKE_CYCLES(WAKE_CYCLES)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev            (ev),
        .commit        (commit),
        .mode_byte     (mode_byte),
        .data_word     (data_word),
        .park_pwr_vld  (park_pwr_vld),
        .park_mode     (park_mode),
        .park_data_vld (park_data_vld),
        .park_data     (park_data),
        .pstate        (pstate),
        .code          (dac_code),
        .ready         (ready)
    );

    dpc_drive #(.N_TERM(N_TERM)) u_drive (
        .pstate       (pstate),
        .amp_en       (amp_en),
        .fast_bias_en (fast_bias_en),
        .term_sel     (term_sel)
    );

    assign term_1k   = term_sel[0];
    assign term_100k = term_sel[1];
    assign term_hiz  = term_sel[2];

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int DATA_W      = 16,
    parameter int WAKE_CYCLES = 250
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [7:0]        cmd_byte,
    input logic              load_strobe,
    input logic [DATA_W-1:0] dac_code,
    input logic              amp_en,
    input logic              fast_bias_en,
    input logic              term_1k,
    input logic              term_100k,
    input logic              term_hiz,
    input logic              ready
);

    // R3
    term_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({term_hiz, term_100k, term_1k}));

    // R3
    term_vs_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_en |-> ($countones({term_hiz, term_100k, term_1k}) == 1));

    // R3
    fast_needs_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_bias_en |-> amp_en);

    // R10
    ready_needs_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> amp_en);

    // R5
    data_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[2:0] == 3'b010 && !load_strobe) |=> amp_en);

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !load_strobe) |=> ($stable(dac_code) && $stable(amp_en)));

    if (WAKE_CYCLES > 0) begin : g_wake
        // R10
        wake_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(amp_en) |-> !ready);
    end

endmodule

bind dac_pwr_ctrl dpc_checker #(.DATA_W(DATA_W), .WAKE_CYCLES(WAKE_CYCLES)) u_dpc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_byte     (cmd_byte),
    .load_strobe  (load_strobe),
    .dac_code     (dac_code),
    .amp_en       (amp_en),
    .fast_bias_en (fast_bias_en),
    .term_1k      (term_1k),
    .term_100k    (term_100k),
    .term_hiz     (term_hiz),
    .ready        (ready)
);

// File: tb/dac_pwr_ctrl_test.sv
module dac_pwr_ctrl_test;

    localparam int DATA_W = 16;
    localparam int WAKE   = 5;
    localparam int NV     = 16;

    typedef struct packed {
        logic        vld;
        logic        stb;
        logic [7:0]  cmd;
        logic [7:0]  mode;
        logic [15:0] dat;
        logic        amp;
        logic        fast;
        logic [2:0]  term;   // {hiz, 100k, 1k}
        logic [15:0] code;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'h03, 8'h20, 16'h0000, 1'b1, 1'b1, 3'b000, 16'h0000, 8'd2},  // R2 fast
        '{1'b1, 1'b0, 8'h02, 8'h00, 16'h1234, 1'b1, 1'b1, 3'b000, 16'h1234, 8'd4},  // R4
        '{1'b1, 1'b0, 8'h03, 8'h40, 16'h0000, 1'b0, 1'b0, 3'b001, 16'h1234, 8'd3},  // R3 1k, R6
        '{1'b1, 1'b0, 8'h03, 8'h60, 16'h0000, 1'b0, 1'b0, 3'b001, 16'h1234, 8'd2},  // R2 01x
        '{1'b1, 1'b0, 8'h03, 8'h80, 16'h0000, 1'b0, 1'b0, 3'b010, 16'h1234, 8'd6},  // R6 100k
        '{1'b1, 1'b0, 8'h03, 8'hE0, 16'h0000, 1'b0, 1'b0, 3'b100, 16'h1234, 8'd3},  // R3 hiz
        '{1'b1, 1'b0, 8'h02, 8'h00, 16'hBEEF, 1'b1, 1'b1, 3'b000, 16'hBEEF, 8'd5},  // R5 back to fast
        '{1'b1, 1'b0, 8'h03, 8'h00, 16'h0000, 1'b1, 1'b0, 3'b000, 16'hBEEF, 8'd2},  // R2 low
        '{1'b1, 1'b0, 8'h01, 8'hA0, 16'h0000, 1'b1, 1'b0, 3'b000, 16'hBEEF, 8'd7},  // R7
        '{1'b1, 1'b0, 8'h00, 8'h00, 16'h0F0F, 1'b1, 1'b0, 3'b000, 16'hBEEF, 8'd8},  // R8
        '{1'b1, 1'b0, 8'h04, 8'h00, 16'h0000, 1'b0, 1'b0, 3'b010, 16'h0F0F, 8'd9},  // R9 both
        '{1'b1, 1'b0, 8'h04, 8'h00, 16'h0000, 1'b0, 1'b0, 3'b010, 16'h0F0F, 8'd9},  // R9 empty
        '{1'b1, 1'b0, 8'h00, 8'h00, 16'h5555, 1'b0, 1'b0, 3'b010, 16'h0F0F, 8'd8},  // R8
        '{1'b0, 1'b1, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, 3'b000, 16'h5555, 8'd9},  // R9 strobe
        '{1'b1, 1'b0, 8'h06, 8'h00, 16'h9999, 1'b1, 1'b0, 3'b000, 16'h5555, 8'd11}, // R11
        '{1'b0, 1'b0, 8'h02, 8'h00, 16'h7777, 1'b1, 1'b0, 3'b000, 16'h5555, 8'd11}  // R11
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_byte = '0;
    logic [7:0]        mode_byte = '0;
    logic [DATA_W-1:0] data_word = '0;
    logic              load_strobe = 1'b0;
    logic [DATA_W-1:0] dac_code;
    logic              amp_en, fast_bias_en, term_1k, term_100k, term_hiz, ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dac_pwr_ctrl #(.DATA_W(DATA_W), .WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .mode_byte(mode_byte), .data_word(data_word), .load_strobe(load_strobe),
        .dac_code(dac_code), .amp_en(amp_en), .fast_bias_en(fast_bias_en),
        .term_1k(term_1k), .term_100k(term_100k), .term_hiz(term_hiz), .ready(ready)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(logic v, logic s, logic [7:0] c, logic [7:0] m, logic [15:0] d);
        @(negedge clk);
        cmd_valid   = v;
        load_strobe = s;
        cmd_byte    = c;
        mode_byte   = m;
        data_word   = d;
        @(negedge clk);
        cmd_valid   = 1'b0;
        load_strobe = 1'b0;
    endtask

    // counts low ready samples from the first falling edge after the exit
    task automatic count_wake(string req);
        int lows = 0;
        while (!ready && lows < 4 * WAKE) begin
            lows++;
            @(negedge clk);
        end
        check(req, lows, WAKE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs", {dac_code, amp_en, fast_bias_en, term_hiz, term_100k, term_1k, ready},
              {16'h0000, 1'b1, 1'b0, 3'b000, 1'b1});

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].vld, VECS[i].stb, VECS[i].cmd, VECS[i].mode, VECS[i].dat);
            check($sformatf("R%0d vec%0d", VECS[i].req, i),
                  {dac_code, amp_en, fast_bias_en, term_hiz, term_100k, term_1k},
                  {VECS[i].code, VECS[i].amp, VECS[i].fast, VECS[i].term});
        end

        // R2 upper command bits set still apply a setting
        send(1'b1, 1'b0, 8'hF1, 8'hC0, 16'h0);
        check("R2 hiz via F1", {amp_en, term_hiz, term_100k, term_1k}, {1'b0, 3'b100});
        // R10 ready low during power-down
        check("R10 ready in pd", ready, 1'b0);
        // R10 wake after data exit
        send(1'b1, 1'b0, 8'h02, 8'h00, 16'hAAAA);
        count_wake("R10 wake data");
        check("R10 ready after", ready, 1'b1);
        // R10 wake after a normal power setting
        send(1'b1, 1'b0, 8'h03, 8'h40, 16'h0);
        send(1'b1, 1'b0, 8'h03, 8'h20, 16'h0);
        check("R2 fast from pd", {amp_en, fast_bias_en}, 2'b11);
        count_wake("R10 wake power");
        // R9 parked setting alone via strobe, code untouched
        send(1'b1, 1'b0, 8'h01, 8'h80, 16'h0);
        check("R7 parked", {amp_en, dac_code}, {1'b1, 16'hAAAA});
        send(1'b0, 1'b1, 8'h00, 8'h00, 16'h0);
        check("R9 strobe setting", {amp_en, term_100k, dac_code}, {2'b01, 16'hAAAA});
        // R5 parked data alone wakes to fast
        send(1'b1, 1'b0, 8'h00, 8'h00, 16'h0321);
        send(1'b0, 1'b1, 8'h00, 8'h00, 16'h0);
        check("R5 loaded data", {amp_en, fast_bias_en, dac_code}, {2'b11, 16'h0321});

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule